// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a simple internal request port and an external 128K x 8 asynchronous static RAM. A requester raises `req` with a direction, an address and, for a write, a data byte. It holds them until `ack` pulses. The controller turns each request into a pin-level cycle on the RAM. It drives a pair of chip selects of opposite polarity, an active-low output enable and an active-low write enable. It also drives the address bus, an outgoing data byte and a separate enable for the bidirectional data pins' output driver. Read data returns on `rdata` in the same cycle as `ack`.

All RAM timing is expressed as whole clock cycles, so a speed grade is chosen by the parameters. `RD_CYC` sets the length of the read window and `WE_CYC` sets how long write enable stays low. `TURN_CYC` sets the extra float time inserted before the controller drives the data pins after the RAM last drove them. Writes are terminated by the rising edge of write enable. Chip select, address and data are held for one more cycle after that edge. Between accesses the RAM is always deselected with every control high and the data driver off.

Top module: `sram_cycle_ctl`

## Requirements
- R1: During reset and in the first cycle after it, the RAM is in standby: `mem_sel_n`=1, `mem_sel`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0, and `ack`=0.
- R2: A read holds `mem_oe_n` low for exactly `RD_CYC` consecutive cycles. Throughout those cycles `mem_sel_n`=0, `mem_sel`=1, `mem_we_n`=1 and `mem_dq_oe`=0.
- R3: `rdata` equals the value on `mem_dq_i` in the last cycle of the read window, and `ack` rises in the following cycle. A read accepted from idle raises `ack` `RD_CYC`+1 cycles after the accepting cycle, or `RD_CYC`+2 when it was requested during the previous `ack`.
- R4: A write holds `mem_we_n` low for exactly `WE_CYC` consecutive cycles. Throughout those cycles the chip is selected, `mem_oe_n`=1 and `mem_dq_oe`=1.
- R5: In the cycle after `mem_we_n` rises, the chip stays selected, `mem_dq_oe` stays 1, and `mem_addr` and `mem_dq_o` are unchanged. `ack` follows one cycle later, and the byte is then stored at the address. A write from idle with no turnaround acks `WE_CYC`+2 cycles after acceptance.
- R6: `mem_dq_oe` is never 1 while `mem_oe_n` is 0 or while the chip is deselected.
- R7: A write whose previous access was a read waits `TURN_CYC` extra standby cycles before selecting the chip. When issued back to back, at least `TURN_CYC`+2 cycles pass between the last cycle with `mem_oe_n` low and the first with `mem_dq_oe` high. A back-to-back write after a read acks in `WE_CYC`+`TURN_CYC`+3 cycles; after a write it acks in `WE_CYC`+3 cycles.
- R8: `ack` lasts exactly one cycle. A request is accepted only in standby while `ack` is low. Changes to `req_write`, `req_addr` or `req_wdata` during an access do not affect it.
- R9: In every cycle where `ack` is 1, the RAM is in standby as defined in R1.
- R10: `mem_addr` does not change while the chip remains selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request, held until `ack` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read data, valid with `ack` of a read |
| mem_addr | output | 17 | RAM address pins |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_o | output | 8 | Data to the RAM pins |
| mem_dq_oe | output | 1 | Output driver enable for the data pins |
| mem_dq_i | input | 8 | Data from the RAM pins |

## Verification
A sequencer stuck in the wrong state shows at once as a control combination outside the truth table. Examples are the data driver on while output enable is low, or write enable low with the chip deselected. Such a state is seen in the very cycle it occurs. A timer loaded with the wrong count shows only when the window closes, as a read or write-enable run that is one cycle short or long. A lost turnaround flag shows as a gap between read output and write drive that is too short. That gap is only visible when a write follows a read directly. A capture on the wrong edge returns the filler byte that the RAM model presents before its access time has elapsed.

// File: rtl/sram_cyc_pkg.sv
package sram_cyc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_TURN  = 3'd1,
        ST_READ  = 3'd2,
        ST_WRITE = 3'd3,
        ST_WEND  = 3'd4
    } cyc_state_e;

    typedef struct packed {
        logic sel_n;
        logic sel;
        logic oe_n;
        logic we_n;
        logic drive;
    } pin_ctl_t;

    localparam pin_ctl_t PINS_STANDBY = '{sel_n: 1'b1, sel: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};

    function automatic pin_ctl_t pins_for(cyc_state_e s);
        pin_ctl_t p;
        p = PINS_STANDBY;
        case (s)
            ST_READ: begin
                p.sel_n = 1'b0;
                p.sel   = 1'b1;
                p.oe_n  = 1'b0;
            end
            ST_WRITE: begin
                p.sel_n = 1'b0;
                p.sel   = 1'b1;
                p.we_n  = 1'b0;
                p.drive = 1'b1;
            end
            ST_WEND: begin
                p.sel_n = 1'b0;
                p.sel   = 1'b1;
                p.drive = 1'b1;
            end
            default: p = PINS_STANDBY;
        endcase
        return p;
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // width holding values 0 .. v-1
    function automatic int unsigned cnt_width(int unsigned v);
        return (v <= 2) ? 1 : $clog2(v);
    endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_cyc_fsm.sv
module sram_cyc_fsm
    import sram_cyc_pkg::*;
#(
    parameter int RD_CYC   = 2,
    parameter int WE_CYC   = 2,
    parameter int TURN_CYC = 1,
    parameter int CW       = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          req_write,
    input  logic          tmr_zero,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output cyc_state_e    state_nxt,
    output logic          accept,
    output logic          rd_done,
    output logic          ack
);
    localparam bit            HAS_TURN = (TURN_CYC > 0);
    localparam logic [CW-1:0] RD_LD    = CW'(RD_CYC - 1);
    localparam logic [CW-1:0] WE_LD    = CW'(WE_CYC - 1);
    localparam logic [CW-1:0] TURN_LD  = CW'(HAS_TURN ? TURN_CYC - 1 : 0);

    cyc_state_e state_q;
    logic       ack_q;
    logic       last_rd_q;
    logic       wr_done;

    always_comb begin
        state_nxt = state_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        accept    = 1'b0;
        rd_done   = 1'b0;
        wr_done   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req && !ack_q) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    if (!req_write) begin
                        state_nxt = ST_READ;
                        tmr_val   = RD_LD;
                    end else if (HAS_TURN && last_rd_q) begin
                        state_nxt = ST_TURN;
                        tmr_val   = TURN_LD;
                    end else begin
                        state_nxt = ST_WRITE;
                        tmr_val   = WE_LD;
                    end
                end
            end
            ST_TURN: begin
                if (tmr_zero) begin
                    state_nxt = ST_WRITE;
                    tmr_load  = 1'b1;
                    tmr_val   = WE_LD;
                end
            end
            ST_READ: begin
                if (tmr_zero) begin
                    state_nxt = ST_IDLE;
                    rd_done   = 1'b1;
                end
            end
            ST_WRITE: begin
                if (tmr_zero) state_nxt = ST_WEND;
            end
            ST_WEND: begin
                state_nxt = ST_IDLE;
                wr_done   = 1'b1;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            ack_q     <= 1'b0;
            last_rd_q <= 1'b0;
        end else begin
            state_q <= state_nxt;
            ack_q   <= rd_done | wr_done;
            if (rd_done)      last_rd_q <= 1'b1;
            else if (wr_done) last_rd_q <= 1'b0;
        end
    end

    assign ack = ack_q;
endmodule

// File: rtl/sram_cyc_datapath.sv
module sram_cyc_datapath
    import sram_cyc_pkg::*;
#(
    parameter int AW = 17,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  cyc_state_e    state_nxt,
    input  logic          rd_done,
    input  logic [DW-1:0] dq_in,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] dq_out,
    output pin_ctl_t      pins,
    output logic [DW-1:0] rdata
);
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;
    pin_ctl_t      pins_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            pins_q  <= PINS_STANDBY;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (rd_done) rdata_q <= dq_in;
            pins_q <= pins_for(state_nxt);
        end
    end

    assign addr   = addr_q;
    assign dq_out = wdata_q;
    assign pins   = pins_q;
    assign rdata  = rdata_q;
endmodule

// File: rtl/sram_cycle_ctl.sv
module sram_cycle_ctl
    import sram_cyc_pkg::*;
#(
    parameter int AW       = 17,
    parameter int DW       = 8,
    parameter int RD_CYC   = 2,
    parameter int WE_CYC   = 2,
    parameter int TURN_CYC = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          ack,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_sel_n,
    output logic          mem_sel,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [DW-1:0] mem_dq_o,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_i
);
    localparam int unsigned MAXC = max3(RD_CYC, WE_CYC, TURN_CYC);
    localparam int          CW   = cnt_width(MAXC);

    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_zero;
    cyc_state_e    state_nxt;
    logic          accept;
    logic          rd_done;
    pin_ctl_t      pins;

    initial begin
        if (RD_CYC < 1 || WE_CYC < 1 || TURN_CYC < 0)
            $error("sram_cycle_ctl: RD_CYC and WE_CYC must be at least 1");
    end

    sram_cyc_timer #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    sram_cyc_fsm #(
        .RD_CYC   (RD_CYC),
        .WE_CYC   (WE_CYC),
        .TURN_CYC (TURN_CYC),
        .CW       (CW)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .req_write (req_write),
        .tmr_zero  (tmr_zero),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .state_nxt (state_nxt),
        .accept    (accept),
        .rd_done   (rd_done),
        .ack       (ack)
    );

    sram_cyc_datapath #(.AW(AW), .DW(DW)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .state_nxt (state_nxt),
        .rd_done   (rd_done),
        .dq_in     (mem_dq_i),
        .addr      (mem_addr),
        .dq_out    (mem_dq_o),
        .pins      (pins),
        .rdata     (rdata)
    );

    assign mem_sel_n = pins.sel_n;
    assign mem_sel   = pins.sel;
    assign mem_oe_n  = pins.oe_n;
    assign mem_we_n  = pins.we_n;
    assign mem_dq_oe = pins.drive;
endmodule

// File: rtl/sram_cycle_ctl_chk.sv
module sram_cycle_ctl_chk #(
    parameter int AW     = 17,
    parameter int DW     = 8,
    parameter int RD_CYC = 2,
    parameter int WE_CYC = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          ack,
    input logic [AW-1:0] mem_addr,
    input logic          mem_sel_n,
    input logic          mem_sel,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic [DW-1:0] mem_dq_o,
    input logic          mem_dq_oe
);
    logic [15:0] rd_run;
    logic [15:0] we_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_run <= '0;
            we_run <= '0;
        end else begin
            rd_run <= mem_oe_n ? 16'd0 : rd_run + 16'd1;
            we_run <= mem_we_n ? 16'd0 : we_run + 16'd1;
        end
    end

    AST_ACK_STANDBY: assert property (@(posedge clk) disable iff (rst)
        ack |-> (mem_sel_n && !mem_sel && mem_oe_n && mem_we_n && !mem_dq_oe)); // R9
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack); // R8
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_dq_oe); // R6
    AST_DRIVE_SELECTED: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (!mem_sel_n && mem_sel && mem_oe_n)); // R6
    AST_WE_SELECTED: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_sel_n && mem_sel && mem_oe_n && mem_dq_oe)); // R4
    AST_WE_RISE_HOLD: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (!mem_sel_n && mem_dq_oe && $stable(mem_dq_o) && $stable(mem_addr))); // R5
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!mem_sel_n && $past(!mem_sel_n)) |-> $stable(mem_addr)); // R10
    AST_READ_LEN: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_oe_n) |-> (rd_run == 16'(RD_CYC))); // R2
    AST_WE_LEN: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (we_run == 16'(WE_CYC))); // R4
endmodule

bind sram_cycle_ctl sram_cycle_ctl_chk #(
    .AW     (AW),
    .DW     (DW),
    .RD_CYC (RD_CYC),
    .WE_CYC (WE_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ack       (ack),
    .mem_addr  (mem_addr),
    .mem_sel_n (mem_sel_n),
    .mem_sel   (mem_sel),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_cycle_ctl_tb.sv
module sram_cycle_ctl_tb;
    localparam int AW       = 17;
    localparam int DW       = 8;
    localparam int RD_CYC   = 2;
    localparam int WE_CYC   = 2;
    localparam int TURN_CYC = 1;
    localparam int NVEC     = 10;

    // {write, addr, wdata, expected read data}
    localparam logic [33:0] VEC [NVEC] = '{
        {1'b1, 17'h00000, 8'hA5, 8'h00},
        {1'b1, 17'h1FFFF, 8'h3C, 8'h00},
        {1'b1, 17'h0AAAA, 8'h96, 8'h00},
        {1'b0, 17'h00000, 8'h00, 8'hA5},
        {1'b0, 17'h1FFFF, 8'h00, 8'h3C},
        {1'b1, 17'h00000, 8'hFF, 8'h00},
        {1'b0, 17'h00000, 8'h00, 8'hFF},
        {1'b0, 17'h0AAAA, 8'h00, 8'h96},
        {1'b1, 17'h15555, 8'h00, 8'h00},
        {1'b0, 17'h15555, 8'h00, 8'h00}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          ack;
    logic [DW-1:0] rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_o;
    logic [DW-1:0] mem_dq_i;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    sram_cycle_ctl #(
        .AW(AW), .DW(DW), .RD_CYC(RD_CYC), .WE_CYC(WE_CYC), .TURN_CYC(TURN_CYC)
    ) u_dut (
        .clk(clk), .rst(rst), .req(req), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .rdata(rdata),
        .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    // RAM model: data valid only once RD_CYC read cycles have elapsed
    logic [7:0] mem [int];
    int         rd_run = 0;

    always @* begin
        if (!mem_sel_n && mem_sel && !mem_oe_n && mem_we_n && rd_run >= RD_CYC)
            mem_dq_i = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'hC3;
        else
            mem_dq_i = 8'hEE;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    function automatic bit standby();
        return mem_sel_n && !mem_sel && mem_oe_n && mem_we_n && !mem_dq_oe;
    endfunction

    // pin monitor
    int            rd_cnt = 0, we_cnt = 0, since_rd = 1000;
    bit            rd_bad = 0, wr_bad = 0, addr_bad = 0;
    logic          p_oe_n = 1'b1, p_we_n = 1'b1, p_sel = 1'b0, p_dq_oe = 1'b0;
    logic [AW-1:0] p_addr = '0;
    logic [DW-1:0] p_dq_o = '0;

    always @(negedge clk) begin
        bit sel;
        sel = !mem_sel_n && mem_sel;
        if (rst) begin
            rd_cnt = 0; we_cnt = 0; since_rd = 1000;
            rd_bad = 0; wr_bad = 0; addr_bad = 0; rd_run = 0;
        end else begin
            if (!mem_oe_n) begin
                rd_cnt++;
                if (!sel || !mem_we_n || mem_dq_oe) rd_bad = 1;
                since_rd = 0;
            end else begin
                if (!p_oe_n) check(rd_cnt == RD_CYC && !rd_bad, "R2 read window", rd_cnt, RD_CYC);
                if (mem_dq_oe && !p_dq_oe && since_rd < 1000)
                    check(since_rd >= TURN_CYC + 2, "R7 float gap", since_rd, TURN_CYC + 2);
                rd_cnt = 0; rd_bad = 0;
                if (since_rd < 1000) since_rd++;
            end
            if (!mem_we_n) begin
                we_cnt++;
                if (!(sel && mem_oe_n && mem_dq_oe)) wr_bad = 1;
            end else if (!p_we_n) begin
                check(we_cnt == WE_CYC && !wr_bad, "R4 write pulse", we_cnt, WE_CYC);
                check(sel && mem_dq_oe && mem_dq_o == p_dq_o && mem_addr == p_addr,
                      "R5 write end hold", int'(mem_dq_o), int'(p_dq_o));
                mem[int'(mem_addr)] = mem_dq_o;
                we_cnt = 0; wr_bad = 0;
            end
            if (sel && p_sel && mem_addr != p_addr) addr_bad = 1;
            if (!sel && p_sel) begin
                check(!addr_bad, "R10 address stable", int'(addr_bad), 0);
                addr_bad = 0;
            end
            rd_run = (sel && !mem_oe_n && mem_we_n) ? rd_run + 1 : 0;
        end
        p_oe_n = mem_oe_n; p_we_n = mem_we_n; p_sel = sel;
        p_dq_oe = mem_dq_oe; p_addr = mem_addr; p_dq_o = mem_dq_o;
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    // called at a falling edge; returns at the falling edge where ack is seen
    task automatic do_op(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         output logic [DW-1:0] rd, output int lat);
        req = 1'b1; req_write = w; req_addr = a; req_wdata = d; lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!ack && lat < 60);
        check(ack == 1'b1, "R8 ack timeout", lat, 0);
        check(standby(), "R9 standby during ack", int'(mem_oe_n), 1);
        rd = rdata;
        req = 1'b0;
    endtask

    initial begin
        logic [DW-1:0] rd;
        int lat;

        repeat (3) @(negedge clk);
        check(standby() && !ack, "R1 standby in reset", int'(ack), 0);
        rst = 1'b0;
        @(negedge clk);
        check(standby() && !ack, "R1 standby after reset", int'(ack), 0);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            do_op(VEC[i][33], VEC[i][32:16], VEC[i][15:8], rd, lat);
            if (!VEC[i][33]) check(rd == VEC[i][7:0], "R3 read data", int'(rd), int'(VEC[i][7:0]));
            else             check(mem[int'(VEC[i][32:16])] == VEC[i][15:8], "R5 stored byte",
                                   int'(mem[int'(VEC[i][32:16])]), int'(VEC[i][15:8]));
            @(negedge clk);
        end

        // isolated read latency, ack single cycle
        do_op(1'b0, 17'h0AAAA, 8'h00, rd, lat);
        check(lat == RD_CYC + 1, "R3 read latency", lat, RD_CYC + 1);
        check(rd == 8'h96, "R3 read data", int'(rd), 8'h96);
        @(negedge clk);
        check(!ack, "R8 ack one cycle", int'(ack), 0);

        // isolated write latency after a write
        do_op(1'b1, 17'h00123, 8'h11, rd, lat);
        @(negedge clk);
        do_op(1'b1, 17'h00124, 8'h22, rd, lat);
        check(lat == WE_CYC + 2, "R5 write latency", lat, WE_CYC + 2);
        @(negedge clk);

        // back to back: read -> read, read -> write, write -> write
        do_op(1'b0, 17'h00123, 8'h00, rd, lat);
        do_op(1'b0, 17'h00124, 8'h00, rd, lat);
        check(lat == RD_CYC + 2, "R3 back-to-back read latency", lat, RD_CYC + 2);
        check(rd == 8'h22, "R3 read data", int'(rd), 8'h22);
        do_op(1'b1, 17'h00200, 8'h77, rd, lat);
        check(lat == WE_CYC + TURN_CYC + 3, "R7 write after read latency", lat, WE_CYC + TURN_CYC + 3);
        do_op(1'b1, 17'h00201, 8'h78, rd, lat);
        check(lat == WE_CYC + 3, "R7 write after write latency", lat, WE_CYC + 3);
        @(negedge clk);

        // request inputs changed during a read are ignored
        req = 1'b1; req_write = 1'b0; req_addr = 17'h00200; req_wdata = 8'h00;
        @(negedge clk);
        @(negedge clk);
        req_write = 1'b1; req_addr = 17'h00201; req_wdata = 8'h55;
        check(mem_addr == 17'h00200 && !mem_oe_n, "R8 access unaffected", int'(mem_addr), 17'h00200);
        while (!ack) @(negedge clk);
        check(rdata == 8'h77, "R8 read data kept", int'(rdata), 8'h77);
        req = 1'b0;
        @(negedge clk);
        do_op(1'b0, 17'h00201, 8'h00, rd, lat);
        check(rd == 8'h78, "R8 no stray write", int'(rd), 8'h78);
        @(negedge clk);

        // reset in the middle of a write
        req = 1'b1; req_write = 1'b1; req_addr = 17'h00300; req_wdata = 8'h44;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b1; req = 1'b0;
        @(negedge clk);
        check(standby() && !ack, "R1 standby after mid-access reset", int'(mem_we_n), 1);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(standby() && !ack, "R1 standby after release", int'(mem_sel), 0);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule